// File: doc/BRIEF.md
# Thermal Hot and Trip Signaller

The block sits beside a die temperature sensor and turns its sampled readings into two active-low thermal outputs. The first is a hot/throttle indication. It asserts when a strobed sample reaches a programmable trip point. It releases only after a strobed sample falls below that trip point by a programmable hysteresis margin. While the hot indication is asserted and the auto-throttle enable is set, a thermal-control enable is driven high to engage the hardware throttle mechanism. The hot indication follows power-state rules. It cannot newly assert while the power state is one of the low-power codes. If it is already asserted on entry to a low-power state, it holds until the state returns to normal and a releasing sample arrives.

The second output is a catastrophic trip indication. It latches when any strobed sample reaches a fixed catastrophic temperature (125 °C by default). This happens in any power state and with auto-throttle on or off, and only reset clears it. A fixed number of cycles after the trip indication falls, a core-voltage removal request rises and stays high. A registered out-of-specification flag reports that auto-throttle is disabled.

Two state machines do the work. The hot machine has three states:
- `H_COOL`. Transition *heat* leads to `H_HOT`.
- `H_HOT`. Transition *sleep-while-hot* leads to `H_HOT_LP`, and transition *cool-down* leads back to `H_COOL`.
- `H_HOT_LP`. Transition *wake-hot* leads to `H_HOT`, and transition *wake-cooled* leads to `H_COOL`.

The trip machine also has three states:
- `T_ARMED`. Transition *trip* leads to `T_COUNT`. Transition *trip-immediate* leads to `T_SHUT` when the delay is zero.
- `T_COUNT`. Transition *budget-spent* leads to `T_SHUT`.
- `T_SHUT`. This state is terminal until reset.

Top module: `thermal_guard`

## Requirements
- R1: During reset and in the first cycle after it, hot_n=1, trip_n=1, vcore_off_req=0, ctrl_en=0 and out_of_spec=0.
- R2: When pwr_state is 2'b00 (normal) and a strobed sample with temp_code >= trip_point is taken at a clock edge, hot_n is 0 after that edge.
- R3: When the hot indication is asserted and pwr_state is normal, a strobed sample with temp_code + hyst_deg < trip_point deasserts it (hot_n=1) after that edge. Any other strobed sample leaves it asserted.
- R4: When pwr_state is a low-power code (2'b01 stop-grant, 2'b10 deep sleep, 2'b11 deeper sleep), hot_n does not fall, whatever the samples are.
- R5: If hot_n is 0 while pwr_state is low-power, it stays 0. It is released only by a releasing sample (R3) taken while pwr_state is normal.
- R6: A temp_code with temp_vld low changes neither hot_n nor trip_n.
- R7: A strobed sample with temp_code >= TRIP_C drives trip_n to 0 after that edge, in any power state and for either auto_en value. trip_n then stays 0 until reset.
- R8: vcore_off_req rises exactly SHUT_DELAY cycles after trip_n falls, and then stays 1 until reset.
- R9: ctrl_en is 1 exactly when hot_n is 0 and auto_en is 1.
- R10: out_of_spec equals the inverse of auto_en registered at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_vld | input | 1 | Sample strobe for temp_code |
| temp_code | input | TEMP_W | Unsigned die temperature in °C |
| trip_point | input | TEMP_W | Hot assertion threshold in °C |
| hyst_deg | input | HYST_W | Release margin below trip_point in °C |
| pwr_state | input | 2 | 00 normal, 01 stop-grant, 10 deep sleep, 11 deeper sleep |
| auto_en | input | 1 | Automatic throttle enable |
| hot_n | output | 1 | Active-low hot/throttle indication |
| trip_n | output | 1 | Active-low catastrophic trip, sticky |
| ctrl_en | output | 1 | Hardware thermal-control enable |
| vcore_off_req | output | 1 | Core-voltage removal request |
| out_of_spec | output | 1 | Auto-throttle disabled flag |

## Verification
Directed sequences walk the hot machine through every transition. A sample exactly at the trip point separates a `>=` compare from a `>` compare. Samples one degree inside and exactly at the release margin separate the strict compare from a loose one. Strobed hot samples in each low-power code separate masking from non-masking, and a power-state return without any sample separates the two wake transitions. Constrained random samples clustered around the trip point, with random hysteresis, strobes, power states and enable, hit the mixed orderings. A strobed sample one degree below the catastrophic level, an unstrobed sample above it, and a strobed hit taken in deep sleep with auto-throttle off separate the trip conditions, and the cycle count to the voltage-removal request exposes any off-by-one in the budget counter.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;

    // Power-state codes seen on pwr_state
    typedef enum logic [1:0] {
        PWR_NORMAL    = 2'b00,
        PWR_STOPGRANT = 2'b01,
        PWR_DEEPSLEEP = 2'b10,
        PWR_DEEPER    = 2'b11
    } pwr_state_e;

    // Hot indication machine
    typedef enum logic [1:0] {
        H_COOL   = 2'b00,
        H_HOT    = 2'b01,
        H_HOT_LP = 2'b10
    } hot_state_e;

    // Catastrophic trip machine
    typedef enum logic [1:0] {
        T_ARMED = 2'b00,
        T_COUNT = 2'b01,
        T_SHUT  = 2'b10
    } trip_state_e;

    function automatic logic is_low_power(input logic [1:0] ps);
        return ps != PWR_NORMAL;
    endfunction

endpackage

// File: rtl/tg_hot_fsm.sv
module tg_hot_fsm
    import thermal_guard_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int HYST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] trip_point,
    input  logic [HYST_W-1:0] hyst,
    input  logic              low_power,
    output logic              hot
);

    localparam int SUM_W = TEMP_W + 1;

    hot_state_e state_q, state_d;
    logic [SUM_W-1:0] temp_plus_hyst;
    logic             reach_hit;
    logic             release_hit;

    // Compare stage: threshold reached and release margin cleared
    always_comb begin
        temp_plus_hyst = SUM_W'(temp) + SUM_W'(hyst);
        reach_hit      = sample_vld && (temp >= trip_point);
        release_hit    = sample_vld && (temp_plus_hyst < SUM_W'(trip_point));
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_COOL: begin
                // heat: only in normal power state
                if (!low_power && reach_hit) state_d = H_HOT;
            end
            H_HOT: begin
                if (low_power)        state_d = H_HOT_LP;   // sleep-while-hot
                else if (release_hit) state_d = H_COOL;     // cool-down
            end
            H_HOT_LP: begin
                if (!low_power) begin
                    if (release_hit) state_d = H_COOL;      // wake-cooled
                    else             state_d = H_HOT;       // wake-hot
                end
            end
            default: state_d = H_COOL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= H_COOL;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            H_HOT, H_HOT_LP: hot = 1'b1;
            default:         hot = 1'b0;
        endcase
    end

    a_r2_hot_on_reach: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !low_power && (temp >= trip_point)) |=> hot);

    a_r4_no_new_hot_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot && low_power) |=> !hot);

    a_r5_hold_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
        (hot && low_power) |=> hot);

    a_r6_no_sample_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_vld && !low_power) |=> $stable(hot));

endmodule

// File: rtl/tg_trip_fsm.sv
module tg_trip_fsm
    import thermal_guard_pkg::*;
#(
    parameter int TEMP_W     = 8,
    parameter int TRIP_C     = 125,
    parameter int SHUT_DELAY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [TEMP_W-1:0] temp,
    output logic              tripped,
    output logic              shut_req
);

    localparam int CNT_W = (SHUT_DELAY > 1) ? $clog2(SHUT_DELAY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST =
        (SHUT_DELAY > 0) ? CNT_W'(SHUT_DELAY - 1) : '0;
    localparam logic [TEMP_W-1:0] TRIP_CODE = TEMP_W'(TRIP_C);

    trip_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cat_hit;

    assign cat_hit = sample_vld && (temp >= TRIP_CODE);

    // Next-state and budget counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            T_ARMED: begin
                cnt_d = '0;
                if (cat_hit) begin
                    if (SHUT_DELAY == 0) state_d = T_SHUT;   // trip-immediate
                    else                 state_d = T_COUNT;  // trip
                end
            end
            T_COUNT: begin
                if (cnt_q == CNT_LAST) state_d = T_SHUT;     // budget-spent
                else                   cnt_d   = cnt_q + 1'b1;
            end
            T_SHUT: begin
                state_d = T_SHUT;
            end
            default: state_d = T_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        tripped  = 1'b0;
        shut_req = 1'b0;
        unique case (state_q)
            T_COUNT: tripped = 1'b1;
            T_SHUT: begin
                tripped  = 1'b1;
                shut_req = 1'b1;
            end
            default: ;
        endcase
    end

    // Checker counter: edges elapsed since the trip indication rose
    logic [31:0] since_trip;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          since_trip <= '0;
        else if (tripped && since_trip != '1) since_trip <= since_trip + 1'b1;
    end

    a_r7_trip_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        cat_hit |=> tripped);

    a_r7_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |=> tripped);

    a_r8_req_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
        shut_req |-> tripped);

    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        shut_req |=> shut_req);

    a_r8_req_timing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut_req) |-> (since_trip == 32'(SHUT_DELAY)));

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_guard_pkg::*;
#(
    parameter int TEMP_W     = 8,
    parameter int HYST_W     = 4,
    parameter int TRIP_C     = 125,
    parameter int SHUT_DELAY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_vld,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [TEMP_W-1:0] trip_point,
    input  logic [HYST_W-1:0] hyst_deg,
    input  logic [1:0]        pwr_state,
    input  logic              auto_en,
    output logic              hot_n,
    output logic              trip_n,
    output logic              ctrl_en,
    output logic              vcore_off_req,
    output logic              out_of_spec
);

    logic low_power;
    logic hot;
    logic tripped;
    logic shut_req;
    logic oos_q;

    assign low_power = is_low_power(pwr_state);

    tg_hot_fsm #(
        .TEMP_W (TEMP_W),
        .HYST_W (HYST_W)
    ) u_hot (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (temp_vld),
        .temp       (temp_code),
        .trip_point (trip_point),
        .hyst       (hyst_deg),
        .low_power  (low_power),
        .hot        (hot)
    );

    tg_trip_fsm #(
        .TEMP_W     (TEMP_W),
        .TRIP_C     (TRIP_C),
        .SHUT_DELAY (SHUT_DELAY)
    ) u_trip (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (temp_vld),
        .temp       (temp_code),
        .tripped    (tripped),
        .shut_req   (shut_req)
    );

    // Out-of-specification flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oos_q <= 1'b0;
        else        oos_q <= ~auto_en;
    end

    // Output stage
    always_comb begin
        hot_n         = ~hot;
        trip_n        = ~tripped;
        ctrl_en       = hot & auto_en;
        vcore_off_req = shut_req;
        out_of_spec   = oos_q;
    end

    a_r9_ctrl_needs_hot: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en |-> (!hot_n && auto_en));

    a_r10_oos_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_of_spec == !$past(auto_en)));

    a_r8_req_with_trip: assert property (@(posedge clk) disable iff (!rst_n)
        vcore_off_req |-> !trip_n);

endmodule

// File: tb/thermal_guard_bench.sv
module thermal_guard_bench;

    localparam int TW     = 8;
    localparam int HW     = 4;
    localparam int TRIP_C = 125;
    localparam int DLY    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          temp_vld;
    logic [TW-1:0] temp_code;
    logic [TW-1:0] trip_point;
    logic [HW-1:0] hyst_deg;
    logic [1:0]    pwr_state;
    logic          auto_en;
    logic          hot_n, trip_n, ctrl_en, vcore_off_req, out_of_spec;

    always #10 clk = ~clk;   // 50 MHz

    thermal_guard #(
        .TEMP_W(TW), .HYST_W(HW), .TRIP_C(TRIP_C), .SHUT_DELAY(DLY)
    ) u_thermal_guard (
        .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .temp_code(temp_code),
        .trip_point(trip_point), .hyst_deg(hyst_deg), .pwr_state(pwr_state),
        .auto_en(auto_en), .hot_n(hot_n), .trip_n(trip_n), .ctrl_en(ctrl_en),
        .vcore_off_req(vcore_off_req), .out_of_spec(out_of_spec)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit m_hot, m_trip, m_oos;
    int m_cnt;
    int g_tp = 90;
    int g_hy = 4;

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2/R3/R4/R5/R6 hot_n", hot_n, !m_hot);
        chk("R7 trip_n", trip_n, !m_trip);
        chk("R8 vcore_off_req", vcore_off_req, m_trip && (m_cnt == DLY));
        chk("R9 ctrl_en", ctrl_en, m_hot && auto_en);
        chk("R10 out_of_spec", out_of_spec, m_oos);
    endtask

    // Model of the requirements, advanced once per clock edge
    task automatic model_edge(input bit vld, input int t, input int ps, input bit ae);
        bit lp;
        lp = (ps != 0);
        if (m_trip) begin
            if (m_cnt < DLY) m_cnt++;
        end else if (vld && t >= TRIP_C) begin
            m_trip = 1'b1;
            m_cnt  = 0;
        end
        if (m_hot) begin
            if (!lp && vld && (t < g_tp - g_hy)) m_hot = 1'b0;
        end else if (!lp && vld && t >= g_tp) begin
            m_hot = 1'b1;
        end
        m_oos = !ae;
    endtask

    task automatic step(input bit vld, input int t, input int ps, input bit ae);
        @(negedge clk);
        check_all();
        temp_vld   = vld;
        temp_code  = TW'(t);
        pwr_state  = 2'(ps);
        auto_en    = ae;
        trip_point = TW'(g_tp);
        hyst_deg   = HW'(g_hy);
        @(posedge clk);
        model_edge(vld, t, ps, ae);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        temp_vld  = 1'b0;
        temp_code = '0;
        pwr_state = 2'b00;
        auto_en   = 1'b1;
        m_hot = 0; m_trip = 0; m_oos = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 hot_n", hot_n, 1'b1);
        chk("R1 trip_n", trip_n, 1'b1);
        chk("R1 vcore_off_req", vcore_off_req, 1'b0);
        chk("R1 ctrl_en", ctrl_en, 1'b0);
        chk("R1 out_of_spec", out_of_spec, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        temp_vld = 1'b0; temp_code = '0; trip_point = 8'd90; hyst_deg = 4'd4;
        pwr_state = 2'b00; auto_en = 1'b1;
        do_reset();

        // Directed hot machine walk
        g_tp = 90; g_hy = 4;
        step(1, 80, 0, 1);   // cool
        step(1, 90, 0, 1);   // R2 reach exactly at trip point
        step(0, 60, 0, 1);   // R6 unstrobed low sample ignored
        step(1, 86, 0, 1);   // R3 at margin: 86+4 not < 90, stays hot
        step(1, 85, 0, 1);   // R3 one inside margin: release
        step(1, 100, 1, 1);  // R4 stop-grant masks new hot
        step(1, 110, 3, 1);  // R4 deeper sleep masks new hot
        step(0, 100, 0, 1);  // R6 back to normal, no sample: stays cool
        step(1, 95, 0, 1);   // R2 hot
        step(1, 50, 2, 1);   // R5 entered deep sleep hot: held
        step(1, 40, 2, 1);   // R5 still held in low power
        step(0, 50, 0, 1);   // R5 wake-hot without sample
        step(1, 50, 0, 0);   // R3 release; R10 auto off
        step(1, 95, 0, 0);   // R9 hot but ctrl_en low
        step(1, 95, 0, 1);   // R9 ctrl_en high
        step(1, 40, 1, 1);   // R5 sleep-while-hot
        step(1, 40, 0, 1);   // R5 wake-cooled in one edge
        step(0, 0, 0, 1);

        // Random mix around the trip point
        for (int i = 0; i < 3000; i++) begin
            int t, ps;
            bit vld, ae;
            if ($urandom % 64 == 0) g_hy = int'($urandom % 16);
            vld = ($urandom % 4) != 0;
            t   = 70 + int'($urandom % 50);
            ps  = (($urandom % 3) == 0) ? int'($urandom % 4) : 0;
            ae  = ($urandom % 8) != 0;
            step(vld, t, ps, ae);
        end

        // Catastrophic trip
        step(1, 124, 0, 1);  // R7 one below: no trip
        step(0, 200, 0, 1);  // R6 unstrobed high sample ignored
        step(1, 125, 2, 0);  // R7 trip in deep sleep with auto off
        for (int i = 0; i < DLY + 4; i++) step(0, 30, 0, 1);  // R8 budget count
        step(1, 20, 0, 1);   // R7 sticky
        step(0, 20, 0, 1);

        // Reset clears the trip
        do_reset();
        step(1, 130, 0, 1);
        for (int i = 0; i < DLY + 2; i++) step(0, 30, 1, 1);
        step(0, 30, 0, 1);

        finish_run();
    end

endmodule